// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers 9-bit words between a producer clocked by `wclk` and a consumer clocked by `rclk`. The two clocks may be unrelated or driven from the same source. Storage is a power-of-two array whose depth is a parameter. Write and read pointers cross between the clock domains as Gray codes through two-flop synchronizers. Each pointer carries one extra wrap bit, so a full array can be told apart from an empty one.

Four active-low flags report the fill state. Empty and almost-empty are registered on `rclk`; full and almost-full are registered on `wclk`. The almost thresholds are offsets held in two registers. After reset both offsets are 7. A separate sequencer loads new offsets through strobe inputs.

The shared pin `wen2_ld` is sampled while reset is high, and its level selects the operating mode:
- High selects dual-enable mode, meant for depth expansion. The pin acts as a second write enable.
- Low selects programmable-offset mode. Cycles with the pin low belong to the offset sequencer.

Reads pass through a registered data output. The output bus goes to high impedance when `oe_n` is high.

Top module: `fifo_pf`

## Requirements
- R1: A clock edge with `rst` high clears both pointers and the output register. It drives `empty_n` and `almost_empty_n` low and `full_n` and `almost_full_n` high. It sets both threshold offsets to 7.
- R2: The level of `wen2_ld` while `rst` is high selects the mode, which then holds until the next reset. High (1) selects dual-enable mode; low (0) selects programmable-offset mode.
- R3: A word is written on a rising `wclk` edge only when `wen1_n` is 0 and `wen2_ld` is 1. In programmable-offset mode, a cycle with `wen2_ld` at 0 is an offset-load cycle and writes nothing to the array.
- R4: A word moves into the output register on a rising `rclk` edge only when both `ren1_n` and `ren2_n` are 0. Otherwise the output register holds its value.
- R5: Write enables are ignored while `full_n` is low. Read enables are ignored while `empty_n` is low.
- R6: `full_n` goes low on the write edge that stores the DEPTH-th unread word. `empty_n` goes low on the read edge that takes the last word. A write reaches the read-side flags three `rclk` edges later, and a read reaches the write-side flags three `wclk` edges later.
- R7: `almost_empty_n` is low while the fill level seen by the read side is at or below the empty offset. `almost_full_n` is low while the free space seen by the write side is at or below the full offset.
- R8: The strobes `ofs_wr_empty` and `ofs_wr_full` load `ofs_wdata` into the empty or full offset on a `wclk` edge only in programmable-offset mode. In dual-enable mode they have no effect.
- R9: With `oe_n` high, `dout` is high impedance. With `oe_n` low, `dout` drives the output register.
- R10: Words leave in the order they were written, including across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock, may be tied to `wclk` |
| rst | input | 1 | Synchronous active-high reset, must be seen by both clocks |
| din | input | WIDTH (9) | Write data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Mode select during reset; second write enable or offset-load control afterwards |
| ofs_wr_empty | input | 1 | Strobe from the offset sequencer: load the empty offset |
| ofs_wr_full | input | 1 | Strobe from the offset sequencer: load the full offset |
| ofs_wdata | input | ADDR_W (6) | Offset value to load |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output-bus enable |
| dout | output | WIDTH (9) | Registered read data, tri-stated by `oe_n` |
| empty_n | output | 1 | Low when no word is readable (rclk domain) |
| almost_empty_n | output | 1 | Low when fill level is at or below the empty offset (rclk domain) |
| full_n | output | 1 | Low when no space is free (wclk domain) |
| almost_full_n | output | 1 | Low when free space is at or below the full offset (wclk domain) |

## Verification
The assertions assume that `rst` stays high across at least three edges of each clock, so that the synchronizers and both sides of the block are flushed together. They also assume that offsets change only while no flag decision depends on them, since the empty offset crosses to the read clock as a quasi-static value. The stimulus holds reset for three shared clock edges. It loads offsets only immediately after reset, before any data is written. It leaves idle gaps before checking any flag that depends on the other domain's pointer.

// File: rtl/fifo_pf_pkg.sv
`timescale 1ns/1ps
package fifo_pf_pkg;
  // Operating mode captured from the shared pin during reset
  typedef enum logic {
    MODE_PROG_OFS = 1'b0,
    MODE_DUAL_EN  = 1'b1
  } fifo_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/fifo_pf_sync.sv
`timescale 1ns/1ps
module fifo_pf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_pf_ram.sv
`timescale 1ns/1ps
module fifo_pf_ram #(
  parameter int WIDTH  = 9,
  parameter int ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              rclk,
  input  logic              rst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; synchronous clear keeps it block-RAM friendly
  always_ff @(posedge rclk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/fifo_pf_wr_ctl.sv
`timescale 1ns/1ps
module fifo_pf_wr_ctl
  import fifo_pf_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DEFAULT_OFS = 7
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic              ofs_wr_empty,
  input  logic              ofs_wr_full,
  input  logic [ADDR_W-1:0] ofs_wdata,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              wr_en,
  output logic [ADDR_W:0]   wbin,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] ae_ofs,
  output logic              full_n,
  output logic              almost_full_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0]     DEPTH_P = PW'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] OFS_RST = ADDR_W'(DEFAULT_OFS);

  fifo_mode_e        mode;
  logic [ADDR_W-1:0] af_ofs;
  logic [PW-1:0]     rq_bin, wbin_nx, wlevel, wfree;

  always_comb begin
    for (int i = 0; i < PW; i++) rq_bin[i] = ^(rgray_sync >> i);
  end

  // Both modes need wen2_ld high for a data write; low is either a
  // disabled second enable or an offset-load cycle.
  assign wr_en   = !wen1_n && wen2_ld && full_n;
  assign wbin_nx = wbin + {{(PW-1){1'b0}}, wr_en};
  assign wlevel  = wbin_nx - rq_bin;
  assign wfree   = DEPTH_P - wlevel;

  always_ff @(posedge wclk) begin
    if (rst) begin
      mode          <= wen2_ld ? MODE_DUAL_EN : MODE_PROG_OFS;
      wbin          <= '0;
      wgray         <= '0;
      full_n        <= 1'b1;
      almost_full_n <= 1'b1;
      ae_ofs        <= OFS_RST;
      af_ofs        <= OFS_RST;
    end else begin
      wbin          <= wbin_nx;
      wgray         <= (wbin_nx >> 1) ^ wbin_nx;
      full_n        <= (wlevel != DEPTH_P);
      almost_full_n <= !(wfree <= {1'b0, af_ofs});
      if (mode == MODE_PROG_OFS) begin
        if (ofs_wr_empty) ae_ofs <= ofs_wdata;
        if (ofs_wr_full)  af_ofs <= ofs_wdata;
      end
    end
  end
endmodule

// File: rtl/fifo_pf_rd_ctl.sv
`timescale 1ns/1ps
module fifo_pf_rd_ctl #(
  parameter int ADDR_W = 6
) (
  input  logic              rclk,
  input  logic              rst,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [ADDR_W-1:0] ae_ofs,
  output logic              rd_en,
  output logic [ADDR_W:0]   rbin,
  output logic [ADDR_W:0]   rgray,
  output logic              empty_n,
  output logic              almost_empty_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] wq_bin, rbin_nx, rlevel;

  always_comb begin
    for (int i = 0; i < PW; i++) wq_bin[i] = ^(wgray_sync >> i);
  end

  assign rd_en   = !ren1_n && !ren2_n && empty_n;
  assign rbin_nx = rbin + {{(PW-1){1'b0}}, rd_en};
  assign rlevel  = wq_bin - rbin_nx;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin           <= '0;
      rgray          <= '0;
      empty_n        <= 1'b0;
      almost_empty_n <= 1'b0;
    end else begin
      rbin           <= rbin_nx;
      rgray          <= (rbin_nx >> 1) ^ rbin_nx;
      empty_n        <= (rlevel != '0);
      almost_empty_n <= !(rlevel <= {1'b0, ae_ofs});
    end
  end
endmodule

// File: rtl/fifo_pf.sv
`timescale 1ns/1ps
module fifo_pf
  import fifo_pf_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int ADDR_W      = 6,
  parameter int DEFAULT_OFS = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  din,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic              ofs_wr_empty,
  input  logic              ofs_wr_full,
  input  logic [ADDR_W-1:0] ofs_wdata,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  output logic [WIDTH-1:0]  dout,
  output logic              empty_n,
  output logic              almost_empty_n,
  output logic              full_n,
  output logic              almost_full_n
);
  localparam int PW = ADDR_W + 1;

  logic              wr_en, rd_en;
  logic [PW-1:0]     wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0]     wgray_in_r, rgray_in_w;
  logic [ADDR_W-1:0] ae_ofs;
  logic [WIDTH-1:0]  q_reg;

  fifo_pf_wr_ctl #(.ADDR_W(ADDR_W), .DEFAULT_OFS(DEFAULT_OFS)) u_wr (
    .wclk(wclk), .rst(rst), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .ofs_wr_empty(ofs_wr_empty), .ofs_wr_full(ofs_wr_full),
    .ofs_wdata(ofs_wdata), .rgray_sync(rgray_in_w), .wr_en(wr_en),
    .wbin(wptr_bin), .wgray(wptr_gray), .ae_ofs(ae_ofs),
    .full_n(full_n), .almost_full_n(almost_full_n)
  );

  fifo_pf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .rclk(rclk), .rst(rst), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .wgray_sync(wgray_in_r), .ae_ofs(ae_ofs), .rd_en(rd_en),
    .rbin(rptr_bin), .rgray(rptr_gray), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n)
  );

  fifo_pf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .d(wptr_gray), .q(wgray_in_r)
  );

  fifo_pf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .d(rptr_gray), .q(rgray_in_w)
  );

  fifo_pf_ram #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(wr_en), .waddr(wptr_bin[ADDR_W-1:0]), .wdata(din),
    .rclk(rclk), .rst(rst), .re(rd_en), .raddr(rptr_bin[ADDR_W-1:0]),
    .q(q_reg)
  );

  assign dout = oe_n ? {WIDTH{1'bz}} : q_reg;
endmodule

// File: rtl/fifo_pf_chk.sv
`timescale 1ns/1ps
module fifo_pf_chk #(
  parameter int WIDTH  = 9,
  parameter int ADDR_W = 6
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst,
  input logic              wen1_n,
  input logic              ren1_n,
  input logic              ren2_n,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic              full_n,
  input logic              almost_full_n,
  input logic [ADDR_W:0]   wptr,
  input logic [ADDR_W:0]   rptr,
  input logic [WIDTH-1:0]  qreg
);
  // R1: flags leave reset in their idle state
  a_r1_wr_flags_after_reset: assert property (@(posedge wclk) disable iff (rst)
    $fell(rst) |-> (full_n && almost_full_n));
  a_r1_rd_flags_after_reset: assert property (@(posedge rclk) disable iff (rst)
    $fell(rst) |-> (!empty_n && !almost_empty_n && qreg == '0));

  // R5: no pointer movement past a full or empty array
  a_r5_no_overflow: assert property (@(posedge wclk) disable iff (rst)
    !full_n |=> $stable(wptr));
  a_r5_no_underflow: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |=> $stable(rptr));

  // R3: without the first write enable the write pointer stays put
  a_r3_write_needs_enable: assert property (@(posedge wclk) disable iff (rst)
    wen1_n |=> $stable(wptr));

  // R4: output register holds unless both read enables are low
  a_r4_read_needs_both: assert property (@(posedge rclk) disable iff (rst)
    (ren1_n || ren2_n) |=> $stable(qreg));

  // R7: the almost flags always cover the hard flags
  a_r7_full_implies_af: assert property (@(posedge wclk) disable iff (rst)
    !full_n |-> !almost_full_n);
  a_r7_empty_implies_ae: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |-> !almost_empty_n);
endmodule

bind fifo_pf fifo_pf_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wen1_n(wen1_n),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .empty_n(empty_n),
  .almost_empty_n(almost_empty_n), .full_n(full_n),
  .almost_full_n(almost_full_n), .wptr(wptr_bin), .rptr(rptr_bin),
  .qreg(q_reg)
);

// File: tb/fifo_pf_bench.sv
`timescale 1ns/1ps
module fifo_pf_bench;
  localparam int W = 9;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic wen1_n = 1'b1, wen2_ld = 1'b1;
  logic ofs_wr_empty = 1'b0, ofs_wr_full = 1'b0;
  logic [AW-1:0] ofs_wdata = '0;
  logic ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  wire  [W-1:0]  dout;
  wire  empty_n, almost_empty_n, full_n, almost_full_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fifo_pf u_fifo_pf (
    .wclk(clk), .rclk(clk), .rst(rst), .din(din), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ofs_wr_empty(ofs_wr_empty), .ofs_wr_full(ofs_wr_full),
    .ofs_wdata(ofs_wdata), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .dout(dout), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .full_n(full_n), .almost_full_n(almost_full_n)
  );

  // bit 9 = read (expect bits 8:0 on dout), else write bits 8:0
  localparam logic [9:0] VEC [8] = '{
    10'h101, 10'h0A5, 10'h1FF, 10'h301,
    10'h033, 10'h2A5, 10'h3FF, 10'h233
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [W-1:0] d);
    din = d; wen1_n = 1'b0; tick(1); wen1_n = 1'b1;
  endtask

  task automatic rd();
    ren1_n = 1'b0; ren2_n = 1'b0; tick(1); ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic do_reset(logic pin);
    rst = 1'b1; wen2_ld = pin; tick(3); rst = 1'b0;
  endtask

  function automatic logic [W-1:0] pat(int i);
    return W'(i * 37 + 5);
  endfunction

  initial begin
    // R1 reset state, dual-enable mode
    do_reset(1'b1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 almost_empty_n", almost_empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 almost_full_n", almost_full_n, 1);
    chk("R1 dout", dout, 0);

    // R10 ordering through the vector table
    foreach (VEC[k]) begin
      if (VEC[k][9]) begin
        rd();
        chk("R10 vector read", dout, VEC[k][8:0]);
      end else begin
        wr(VEC[k][8:0]);
      end
      tick(4);
    end
    chk("R6 empty after vectors", empty_n, 0);

    // R3: second enable low blocks the write
    din = 9'h111; wen1_n = 1'b0; wen2_ld = 1'b0; tick(1);
    wen1_n = 1'b1; wen2_ld = 1'b1; tick(4);
    chk("R3 wen2 low writes nothing", empty_n, 0);

    // R4: one read enable alone does nothing
    wr(9'h055); tick(4);
    ren1_n = 1'b0; tick(1); ren1_n = 1'b1;
    chk("R4 only ren1_n low", dout, 9'h033);
    ren2_n = 1'b0; tick(1); ren2_n = 1'b1;
    chk("R4 only ren2_n low", dout, 9'h033);
    rd();
    chk("R4 both enables", dout, 9'h055);

    // R9 output enable
    oe_n = 1'b1; #1;
    checks++;
    if (dout === 9'h055) begin
      fails++;
      $display("FAIL R9 oe_n high actual=%0h expected=not 55", dout);
    end
    oe_n = 1'b0; #1;
    chk("R9 oe_n low drives", dout, 9'h055);
    tick(4);

    // R6/R7/R5 fill
    for (int i = 1; i <= DEPTH; i++) begin
      wr(pat(i));
      if (i == 56) chk("R7 free 8 not almost full", almost_full_n, 1);
      if (i == 57) chk("R7 free 7 almost full", almost_full_n, 0);
      if (i == 63) chk("R6 not yet full", full_n, 1);
      if (i == 64) chk("R6 full on last write", full_n, 0);
    end
    wr(9'h1EE); tick(4);
    chk("R5 still full", full_n, 0);
    chk("R7 almost empty off when full", almost_empty_n, 1);

    // drain, R10 order and R7 almost-empty threshold
    for (int i = 1; i <= DEPTH; i++) begin
      rd();
      chk("R10 drain order", dout, pat(i));
      if (i == 56) chk("R7 level 8 not almost empty", almost_empty_n, 1);
      if (i == 57) chk("R7 level 7 almost empty", almost_empty_n, 0);
    end
    chk("R6 empty on last read", empty_n, 0);
    rd();
    chk("R5 read while empty holds", dout, pat(DEPTH));
    wr(9'h0C3); tick(4);
    rd();
    chk("R5 R10 after wrap", dout, 9'h0C3);

    // R8: strobes ignored in dual-enable mode
    do_reset(1'b1);
    ofs_wdata = '0; ofs_wr_empty = 1'b1; tick(1); ofs_wr_empty = 1'b0;
    for (int i = 0; i < 7; i++) wr(W'(i));
    tick(4);
    chk("R8 default 7 kept, level 7", almost_empty_n, 0);
    wr(9'h007); tick(4);
    chk("R8 default 7 kept, level 8", almost_empty_n, 1);

    // R2/R3/R8: programmable-offset mode
    do_reset(1'b0);
    wen1_n = 1'b0; din = 9'h1AA;
    ofs_wdata = 6'd3; ofs_wr_empty = 1'b1; tick(1); ofs_wr_empty = 1'b0;
    ofs_wdata = 6'd2; ofs_wr_full = 1'b1; tick(1); ofs_wr_full = 1'b0;
    wen1_n = 1'b1; tick(4);
    chk("R3 load cycles write no data", empty_n, 0);
    wen2_ld = 1'b1;
    for (int i = 1; i <= 4; i++) wr(pat(i));
    tick(4);
    chk("R2 prog mode level 4", empty_n, 1);
    chk("R8 empty offset 3, level 4", almost_empty_n, 1);
    rd();
    chk("R8 empty offset 3, level 3", almost_empty_n, 0);
    chk("R10 prog mode first word", dout, pat(1));
    tick(4);
    for (int i = 1; i <= 58; i++) wr(W'(i));
    chk("R8 full offset 2, free 3", almost_full_n, 1);
    wr(9'h000);
    chk("R8 full offset 2, free 2", almost_full_n, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule